// File: doc/BRIEF.md
# Two-Way Set-Associative Byte Cache

This block is a small cache that sits in front of a 256-byte, byte-addressed backing store. It holds 64 bytes, organised as four sets of two ways with 8-byte lines. A requester issues single-byte loads and stores on an 8-bit address. The cache looks the address up in its tag store and reports whether the first lookup hit. On a miss it moves the whole line over a byte-serial next-level port before it completes the request.

The parameter `WRITE_BACK` selects the store policy. When it is set, stores stay in the cache and mark the line modified. A modified line returns to the next level only when it is evicted, and write misses allocate a line. When it is clear, every store goes to the next level as it happens, no line is ever marked modified, and a write miss does not allocate a line.

The block accepts one request at a time. `req_ready` stays low from acceptance until the response cycle.

Top module: `sa_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` and `mem_req` are 0, and every line is invalid, so the first access to any address misses.
- R2: Address bits [7:5] form the tag, bits [4:3] select the set and bits [2:0] pick the byte in the line. A read that hits returns the stored byte with `resp_hit`=1 and issues no next-level traffic.
- R3: A read miss performs exactly 8 next-level read beats, covering the whole line. It responds with `resp_hit`=0 and the correct byte, and later accesses to the same line hit.
- R4: Two lines whose addresses share set bits but differ in tag can be resident together. A miss fills an invalid way before any valid way is replaced.
- R5: When both ways are valid, a miss replaces the way that was not most recently accessed. Every hit and every fill makes the set's replacement bit point away from the way just used.
- R6: With write-back selected, a store hit updates the cached byte, makes no next-level write and leaves the backing store unchanged.
- R7: With write-back selected, evicting a modified line makes 8 next-level write beats carrying the line's current bytes. All of them complete before the first refill read beat.
- R8: Evicting a line that was never modified makes no next-level write.
- R9: With write-back selected, a store miss refills the line (8 read beats), then writes the byte into the cache, responding with `resp_hit`=0.
- R10: With write-through selected, every store makes exactly one next-level write of that byte at that address, whether it hits or misses. A store miss does not allocate, and no line is ever marked modified.
- R11: `req_ready` is low while a lookup, refill, writeback or store-through is in progress. Each accepted request yields a single one-cycle `resp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 8 | Store data |
| req_ready | output | 1 | Cache idle and able to accept a request |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_hit | output | 1 | The first lookup of this request hit |
| resp_rdata | output | 8 | Load data (echoes the store data for stores) |
| mem_req | output | 1 | Next-level beat requested |
| mem_we | output | 1 | Next-level beat is a write |
| mem_addr | output | 8 | Next-level byte address |
| mem_wdata | output | 8 | Next-level write data |
| mem_ack | input | 1 | Next-level beat completes this cycle |
| mem_rdata | input | 8 | Next-level read data, valid with `mem_ack` |

## Verification
The bench builds two instances side by side, one with `WRITE_BACK`=1 and one with `WRITE_BACK`=0, each with its own backing store that acknowledges every beat in the same cycle. The write-back instance makes dirty-victim eviction, write-allocate and the ordering of writeback ahead of refill reachable. The write-through instance makes the single store-through beat and the no-allocate store miss reachable. Beat counts and backing-store contents are compared around each access.

// File: rtl/sac_pkg.sv
package sac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMP,
    ST_WBACK,
    ST_FILL,
    ST_WTHRU
  } sac_state_e;

  // Victim choice for a two-way set: an empty way wins, otherwise the LRU bit decides.
  function automatic logic pick_victim(input logic v0, input logic v1, input logic lru);
    if (!v0)      return 1'b0;
    else if (!v1) return 1'b1;
    else          return lru;
  endfunction

endpackage

// File: rtl/sac_tag_store.sv
module sac_tag_store
  import sac_pkg::*;
#(
  parameter int SET_W      = 2,
  parameter int TAG_W      = 3,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SET_W-1:0]       lk_set,
  input  logic [TAG_W-1:0]       lk_tag,
  output logic                   hit,
  output logic                   hit_way,
  output logic                   vic_way,
  output logic                   vic_valid,
  output logic                   vic_dirty,
  output logic [TAG_W-1:0]       vic_tag,
  input  logic                   touch_en,
  input  logic                   touch_way,
  input  logic                   mark_dirty,
  input  logic                   fill_en,
  input  logic                   fill_way,
  output logic [(1<<SET_W)-1:0]  lru_q,
  output logic                   dirty_any
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0]  valid_q [2];
  logic [SETS-1:0]  dirty_q [2];
  logic [TAG_W-1:0] tag_q   [2][SETS];
  logic [1:0]       match;

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign match[w] = valid_q[w][lk_set] && (tag_q[w][lk_set] == lk_tag);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[w] <= '0;
        for (int s = 0; s < SETS; s++) tag_q[w][s] <= '0;
      end else if (fill_en && (fill_way == 1'(w))) begin
        valid_q[w][lk_set] <= 1'b1;
        tag_q[w][lk_set]   <= lk_tag;
      end
    end

    if (WRITE_BACK) begin : g_dirty
      always_ff @(posedge clk) begin
        if (!rst_n)
          dirty_q[w] <= '0;
        else if (fill_en && (fill_way == 1'(w)))
          dirty_q[w][lk_set] <= 1'b0;
        else if (mark_dirty && (touch_way == 1'(w)))
          dirty_q[w][lk_set] <= 1'b1;
      end
    end else begin : g_clean
      assign dirty_q[w] = '0;
    end
  end

  assign hit     = |match;
  assign hit_way = match[1];

  assign vic_way   = pick_victim(valid_q[0][lk_set], valid_q[1][lk_set], lru_q[lk_set]);
  assign vic_valid = valid_q[vic_way][lk_set];
  assign vic_dirty = dirty_q[vic_way][lk_set];
  assign vic_tag   = tag_q[vic_way][lk_set];
  assign dirty_any = (|dirty_q[0]) | (|dirty_q[1]);

  always_ff @(posedge clk) begin
    if (!rst_n)
      lru_q <= '0;
    else if (fill_en)
      lru_q[lk_set] <= ~fill_way;
    else if (touch_en)
      lru_q[lk_set] <= ~touch_way;
  end

endmodule

// File: rtl/sac_data_store.sv
module sac_data_store #(
  parameter int SET_W  = 2,
  parameter int OFF_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic [SET_W-1:0]  set_idx,
  input  logic              we,
  input  logic              wr_way,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wdata,
  input  logic              a_way,
  input  logic [OFF_W-1:0]  a_off,
  output logic [DATA_W-1:0] a_data,
  input  logic              b_way,
  input  logic [OFF_W-1:0]  b_off,
  output logic [DATA_W-1:0] b_data
);
  localparam int SETS = 1 << SET_W;
  localparam int BLK  = 1 << OFF_W;

  logic [DATA_W-1:0] line_q [2][SETS][BLK];

  always_ff @(posedge clk) begin
    if (we) line_q[wr_way][set_idx][wr_off] <= wdata;
  end

  assign a_data = line_q[a_way][set_idx][a_off];
  assign b_data = line_q[b_way][set_idx][b_off];

endmodule

// File: rtl/sa_cache.sv
module sa_cache
  import sac_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int SET_W      = 2,
  parameter int OFF_W      = 3,
  parameter int DATA_W     = 8,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int TAG_W = ADDR_W - SET_W - OFF_W;
  localparam int SETS  = 1 << SET_W;
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'((1 << OFF_W) - 1);

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: SET_W];
  endfunction
  function automatic logic [OFF_W-1:0] off_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction
  function automatic logic [ADDR_W-1:0] line_addr(input logic [TAG_W-1:0] t,
                                                  input logic [SET_W-1:0] s,
                                                  input logic [OFF_W-1:0] o);
    return {t, s, o};
  endfunction

  sac_state_e        state;
  logic              r_we, r_first, r_hit, v_way;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;
  logic [OFF_W-1:0]  beat;
  logic [TAG_W-1:0]  v_tag;

  logic [TAG_W-1:0]  lk_tag;
  logic [SET_W-1:0]  lk_set;
  logic [OFF_W-1:0]  lk_off;
  logic              hit, hit_way, vic_way, vic_valid, vic_dirty, dirty_any;
  logic [TAG_W-1:0]  vic_tag;
  logic [SETS-1:0]   lru_q;
  logic [DATA_W-1:0] hit_data, ev_data;

  // Named events for the checker
  logic hit_evt, wb_beat, fill_beat, fill_done, need_wb;
  logic ds_we, ds_way;
  logic [OFF_W-1:0]  ds_off;
  logic [DATA_W-1:0] ds_wdata;

  assign lk_tag = tag_of(r_addr);
  assign lk_set = set_of(r_addr);
  assign lk_off = off_of(r_addr);

  assign hit_evt   = (state == ST_CMP) && hit;
  assign wb_beat   = (state == ST_WBACK) && mem_ack;
  assign fill_beat = (state == ST_FILL) && mem_ack;
  assign fill_done = fill_beat && (beat == LAST_BEAT);
  assign need_wb   = WRITE_BACK && vic_valid && vic_dirty;

  assign ds_we    = (hit_evt && r_we) || fill_beat;
  assign ds_way   = fill_beat ? v_way : hit_way;
  assign ds_off   = fill_beat ? beat : lk_off;
  assign ds_wdata = fill_beat ? mem_rdata : r_wdata;

  sac_tag_store #(
    .SET_W(SET_W), .TAG_W(TAG_W), .WRITE_BACK(WRITE_BACK)
  ) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_set(lk_set), .lk_tag(lk_tag),
    .hit(hit), .hit_way(hit_way),
    .vic_way(vic_way), .vic_valid(vic_valid), .vic_dirty(vic_dirty), .vic_tag(vic_tag),
    .touch_en(hit_evt), .touch_way(hit_way),
    .mark_dirty(hit_evt && r_we && WRITE_BACK),
    .fill_en(fill_done), .fill_way(v_way),
    .lru_q(lru_q), .dirty_any(dirty_any)
  );

  sac_data_store #(
    .SET_W(SET_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
  ) u_data (
    .clk(clk), .set_idx(lk_set),
    .we(ds_we), .wr_way(ds_way), .wr_off(ds_off), .wdata(ds_wdata),
    .a_way(hit_way), .a_off(lk_off), .a_data(hit_data),
    .b_way(v_way), .b_off(beat), .b_data(ev_data)
  );

  assign req_ready = (state == ST_IDLE);
  assign mem_req   = (state == ST_WBACK) || (state == ST_FILL) || (state == ST_WTHRU);
  assign mem_we    = (state == ST_WBACK) || (state == ST_WTHRU);
  assign mem_wdata = (state == ST_WBACK) ? ev_data : r_wdata;

  always_comb begin
    case (state)
      ST_WBACK: mem_addr = line_addr(v_tag, lk_set, beat);
      ST_FILL:  mem_addr = line_addr(lk_tag, lk_set, beat);
      default:  mem_addr = r_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_rdata <= '0;
      r_we       <= 1'b0;
      r_addr     <= '0;
      r_wdata    <= '0;
      r_first    <= 1'b0;
      r_hit      <= 1'b0;
      beat       <= '0;
      v_way      <= 1'b0;
      v_tag      <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            r_we    <= req_write;
            r_addr  <= req_addr;
            r_wdata <= req_wdata;
            r_first <= 1'b1;
            state   <= ST_CMP;
          end
        end
        ST_CMP: begin
          if (r_we && !WRITE_BACK) begin
            r_hit <= hit && r_first;
            state <= ST_WTHRU;
          end else if (hit) begin
            resp_valid <= 1'b1;
            resp_hit   <= r_first;
            resp_rdata <= r_we ? r_wdata : hit_data;
            state      <= ST_IDLE;
          end else begin
            v_way   <= vic_way;
            v_tag   <= vic_tag;
            beat    <= '0;
            r_first <= 1'b0;
            state   <= need_wb ? ST_WBACK : ST_FILL;
          end
        end
        ST_WBACK: begin
          if (mem_ack) begin
            beat <= beat + 1'b1;
            if (beat == LAST_BEAT) state <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            beat <= beat + 1'b1;
            if (beat == LAST_BEAT) state <= ST_CMP;
          end
        end
        ST_WTHRU: begin
          if (mem_ack) begin
            resp_valid <= 1'b1;
            resp_hit   <= r_hit;
            resp_rdata <= r_wdata;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sa_cache_chk.sv
module sa_cache_chk #(
  parameter int SET_W      = 2,
  parameter bit WRITE_BACK = 1'b1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_ready,
  input logic                  resp_valid,
  input logic                  mem_req,
  input logic                  hit_evt,
  input logic                  hit_way,
  input logic [SET_W-1:0]      lk_set,
  input logic                  wb_beat,
  input logic                  fill_beat,
  input logic                  fill_done,
  input logic [(1<<SET_W)-1:0] lru_q,
  input logic                  dirty_any
);
  // R11: no acceptance while the next-level port is busy
  p_busy_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  // R11: responses are single-cycle pulses
  p_resp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  // R3: a completed refill is followed by a hitting lookup
  p_fill_then_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> hit_evt);

  // R7: a writeback beat never follows a refill beat of the same miss
  p_wb_before_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_beat |=> !wb_beat);

  // R5: after a hit the replacement bit points at the other way
  p_lru_away_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> (lru_q[$past(lk_set)] == !$past(hit_way)));

  // R10: store-through never marks lines or writes back lines
  p_wt_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (WRITE_BACK == 1'b0) |-> (!dirty_any && !wb_beat));

endmodule

bind sa_cache sa_cache_chk #(.SET_W(SET_W), .WRITE_BACK(WRITE_BACK)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .resp_valid(resp_valid),
  .mem_req(mem_req), .hit_evt(hit_evt), .hit_way(hit_way), .lk_set(lk_set),
  .wb_beat(wb_beat), .fill_beat(fill_beat), .fill_done(fill_done),
  .lru_q(lru_q), .dirty_any(dirty_any)
);

// File: tb/sim_sa_cache.sv
`timescale 1ns/1ps
module sim_sa_cache;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       req_valid [2];
  logic       req_write [2];
  logic [7:0] req_addr  [2];
  logic [7:0] req_wdata [2];
  logic       req_ready [2];
  logic       resp_valid[2];
  logic       resp_hit  [2];
  logic [7:0] resp_rdata[2];
  logic       mem_req   [2];
  logic       mem_we    [2];
  logic [7:0] mem_addr  [2];
  logic [7:0] mem_wdata [2];
  logic       mem_ack   [2];
  logic [7:0] mem_rdata [2];

  logic [7:0] bmem [2][256];
  logic [7:0] expv [2][256];
  int rd_cnt [2];
  int wr_cnt [2];
  int viol   [2];
  logic seen_rd [2];
  int n_chk = 0;
  int n_err = 0;

  function automatic logic [7:0] init_val(input int a);
    return 8'((a * 13) + 7);
  endfunction

  sa_cache #(.WRITE_BACK(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[0]), .req_write(req_write[0]),
    .req_addr(req_addr[0]), .req_wdata(req_wdata[0]), .req_ready(req_ready[0]),
    .resp_valid(resp_valid[0]), .resp_hit(resp_hit[0]), .resp_rdata(resp_rdata[0]),
    .mem_req(mem_req[0]), .mem_we(mem_we[0]), .mem_addr(mem_addr[0]),
    .mem_wdata(mem_wdata[0]), .mem_ack(mem_ack[0]), .mem_rdata(mem_rdata[0]));

  sa_cache #(.WRITE_BACK(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[1]), .req_write(req_write[1]),
    .req_addr(req_addr[1]), .req_wdata(req_wdata[1]), .req_ready(req_ready[1]),
    .resp_valid(resp_valid[1]), .resp_hit(resp_hit[1]), .resp_rdata(resp_rdata[1]),
    .mem_req(mem_req[1]), .mem_we(mem_we[1]), .mem_addr(mem_addr[1]),
    .mem_wdata(mem_wdata[1]), .mem_ack(mem_ack[1]), .mem_rdata(mem_rdata[1]));

  // Backing stores: every beat acknowledged in the cycle it is requested
  always_comb begin
    for (int s = 0; s < 2; s++) begin
      mem_ack[s]   = mem_req[s];
      mem_rdata[s] = bmem[s][mem_addr[s]];
    end
  end

  always @(posedge clk) begin
    for (int s = 0; s < 2; s++) begin
      if (!rst_n) begin
        for (int a = 0; a < 256; a++) bmem[s][a] <= init_val(a);
        rd_cnt[s] <= 0; wr_cnt[s] <= 0; viol[s] <= 0; seen_rd[s] <= 1'b0;
      end else begin
        if (req_valid[s] && req_ready[s]) seen_rd[s] <= 1'b0;
        if (mem_req[s] && mem_ack[s]) begin
          if (mem_we[s]) begin
            bmem[s][mem_addr[s]] <= mem_wdata[s];
            wr_cnt[s] <= wr_cnt[s] + 1;
            if (seen_rd[s]) viol[s] <= viol[s] + 1;
          end else begin
            rd_cnt[s] <= rd_cnt[s] + 1;
            seen_rd[s] <= 1'b1;
          end
        end
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic access(input int s, input bit we, input logic [7:0] a, input logic [7:0] d,
                        output logic [7:0] q, output bit h, output int nr, output int nw);
    int r0, w0, n;
    r0 = rd_cnt[s]; w0 = wr_cnt[s];
    @(negedge clk);
    req_valid[s] = 1'b1; req_write[s] = we; req_addr[s] = a; req_wdata[s] = d;
    @(negedge clk);
    req_valid[s] = 1'b0;
    chk("R11 ready low after acceptance", int'(req_ready[s]), 0);
    n = 0;
    while (!resp_valid[s] && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk("R11 response arrives", int'(resp_valid[s]), 1);
    q = resp_rdata[s]; h = resp_hit[s];
    nr = rd_cnt[s] - r0; nw = wr_cnt[s] - w0;
    if (we) expv[s][a] = d;
    @(negedge clk);
    chk("R11 single-cycle response", int'(resp_valid[s]), 0);
  endtask

  task automatic rd(input int s, input logic [7:0] a, input bit eh, input int enr,
                    input int enw, input string tag);
    logic [7:0] q; bit h; int nr, nw;
    access(s, 1'b0, a, 8'h00, q, h, nr, nw);
    chk({tag, " read data"}, int'(q), int'(expv[s][a]));
    chk({tag, " hit flag"}, int'(h), int'(eh));
    chk({tag, " read beats"}, nr, enr);
    chk({tag, " write beats"}, nw, enw);
  endtask

  task automatic wr(input int s, input logic [7:0] a, input logic [7:0] d, input bit eh,
                    input int enr, input int enw, input string tag);
    logic [7:0] q; bit h; int nr, nw;
    access(s, 1'b1, a, d, q, h, nr, nw);
    chk({tag, " hit flag"}, int'(h), int'(eh));
    chk({tag, " read beats"}, nr, enr);
    chk({tag, " write beats"}, nw, enw);
  endtask

  task automatic t_reset;
    for (int s = 0; s < 2; s++) begin
      chk("R1 ready after reset", int'(req_ready[s]), 1);
      chk("R1 no response after reset", int'(resp_valid[s]), 0);
      chk("R1 no memory request after reset", int'(mem_req[s]), 0);
    end
  endtask

  task automatic t_fill_hit;
    rd(0, 8'h00, 1'b0, 8, 0, "R1 R3 cold miss");
    rd(0, 8'h05, 1'b1, 0, 0, "R2 R3 same line hit");
    rd(0, 8'h07, 1'b1, 0, 0, "R2 last byte hit");
  endtask

  task automatic t_two_ways;
    rd(0, 8'h20, 1'b0, 8, 0, "R4 second tag fills empty way");
    rd(0, 8'h00, 1'b1, 0, 0, "R4 first tag still resident");
    rd(0, 8'h21, 1'b1, 0, 0, "R4 second tag resident");
  endtask

  task automatic t_lru;
    rd(0, 8'h00, 1'b1, 0, 0, "R5 touch way of 0x00");
    rd(0, 8'h40, 1'b0, 8, 0, "R5 R8 clean victim replaced");
    rd(0, 8'h00, 1'b1, 0, 0, "R5 recently used line kept");
    rd(0, 8'h20, 1'b0, 8, 0, "R5 least recent line evicted");
  endtask

  task automatic t_wb_store;
    wr(0, 8'h02, 8'hC3, 1'b1, 0, 0, "R6 store hit");
    chk("R6 backing store unchanged", int'(bmem[0][8'h02]), int'(init_val(8'h02)));
    rd(0, 8'h02, 1'b1, 0, 0, "R6 stored byte read back");
  endtask

  task automatic t_wb_evict;
    int v0;
    wr(0, 8'h08, 8'h11, 1'b0, 8, 0, "R9 store miss allocates");
    rd(0, 8'h0F, 1'b1, 0, 0, "R9 allocated line hits");
    rd(0, 8'h28, 1'b0, 8, 0, "R4 second way of set 1");
    v0 = viol[0];
    rd(0, 8'h48, 1'b0, 8, 8, "R7 dirty victim written back");
    chk("R7 writeback precedes refill", viol[0] - v0, 0);
    chk("R7 modified byte reached memory", int'(bmem[0][8'h08]), 32'h11);
    chk("R7 neighbour byte intact", int'(bmem[0][8'h09]), int'(init_val(8'h09)));
    rd(0, 8'h08, 1'b0, 8, 0, "R8 clean victim no writeback");
  endtask

  task automatic t_wt;
    wr(1, 8'h10, 8'h77, 1'b0, 0, 1, "R10 store miss through");
    chk("R10 store-through miss data", int'(bmem[1][8'h10]), 32'h77);
    rd(1, 8'h10, 1'b0, 8, 0, "R10 no allocate on store miss");
    wr(1, 8'h11, 8'h99, 1'b1, 0, 1, "R10 store hit through");
    chk("R10 store-through hit data", int'(bmem[1][8'h11]), 32'h99);
    rd(1, 8'h11, 1'b1, 0, 0, "R10 cache updated on store hit");
    rd(1, 8'h30, 1'b0, 8, 0, "R10 fill second way");
    rd(1, 8'h50, 1'b0, 8, 0, "R10 R8 eviction without writeback");
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin
      req_valid[s] = 1'b0; req_write[s] = 1'b0; req_addr[s] = '0; req_wdata[s] = '0;
      for (int a = 0; a < 256; a++) expv[s][a] = init_val(a);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_fill_hit;
    t_two_ways;
    t_lru;
    t_wb_store;
    t_wb_evict;
    t_wt;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule